// File: doc/BRIEF.md
# Stack Pointer and Subroutine Call/Return Unit

This block owns the stack pointer of a small controller whose stack sits in a 128-byte on-chip data RAM. It executes single-byte push and pop requests and the two-byte save and restore of a 16-bit program counter needed by subroutine calls and returns. The stack grows toward higher addresses. A push first advances the pointer and then stores at the new location. A pop reads the current location and then steps the pointer back.

The RAM array is inside the block, and its write and read address, data and strobes are also brought out as ports. This lets a surrounding datapath see every access. A call stores the return address over two cycles: low byte first, then high byte. A return reads the two bytes back in the opposite order and presents the rebuilt PC with a one-cycle valid flag. A direct pointer write lets software relocate the stack, for example to keep it clear of the register banks.

Top module: `stack_call_unit`

## Requirements
- R1: After a synchronous active-low reset the pointer reads 07h and busy, pop_valid, pc_valid, ovf and ram_we are all 0, so the first push stores at location 08h.
- R2: A push accepted in a cycle drives ram_we=1, ram_addr=SP+1 and ram_wdata=push_data in that same cycle, and the new SP is visible on sp_out after the clock edge (pushing 55h then 4Ah from 07h leaves 55h at 08h, 4Ah at 09h and SP=09h).
- R3: A pop accepted in a cycle drives ram_re=1 and ram_addr=SP with ram_we=0. In the following cycle pop_data holds the byte stored at that address and pop_valid is 1 for exactly one cycle. SP decrements at the edge.
- R4: A call writes call_addr[7:0] at SP+1 in the accepting cycle and call_addr[15:8] at SP+2 in the next cycle, with busy=1 during that second cycle. SP ends two higher.
- R5: A return reads the top entry (placed in pc_out[15:8]) in the accepting cycle and the entry beneath it (placed in pc_out[7:0]) in the following busy cycle. In the cycle after that, pc_valid is 1 for one cycle. SP ends two lower.
- R6: While busy=1, push, pop, call, return and direct-write strobes are ignored. Only the second access of the sequence in progress reaches the RAM and the pointer.
- R7: When several strobes arrive together while idle, exactly one is taken, in the priority order: direct write, call, return, push, pop.
- R8: The pointer steps modulo 128: every increment or decrement clears bit 7, and ram_addr is SP bits 6:0. An increment from a low part of 7Fh gives SP=00h and raises ovf for the one cycle after that edge. A decrement from 00h gives 7Fh with no flag.
- R9: An accepted direct write loads sp_wr_data into SP at the edge and makes no RAM access in that cycle (ram_we=0, ram_re=0).
- R10: With SP set to 5Fh, 32 pushes fill 60h through 7Fh without ovf, and the 33rd push wraps to location 00h with ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Save a return address |
| call_addr | input | 16 | Return address to save |
| ret_req | input | 1 | Restore a return address |
| sp_wr_en | input | 1 | Direct pointer write |
| sp_wr_data | input | 8 | New pointer value |
| ram_addr | output | 7 | RAM address of the current access |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| pop_data | output | 8 | Byte returned by the last pop |
| pop_valid | output | 1 | pop_data valid, one cycle |
| pc_out | output | 16 | Restored program counter |
| pc_valid | output | 1 | pc_out valid, one cycle |
| busy | output | 1 | Second cycle of a call or return |
| sp_out | output | 8 | Current stack pointer |
| ovf | output | 1 | Pointer wrapped past 7Fh, one cycle |

## Verification
The hardest cases to reach are the collisions: strobes that arrive in the second cycle of a call or return, and a two-byte save that straddles the 7Fh-to-00h wrap. The bench produces the first by raising every strobe at once during the busy cycle. It then checks that the pointer, the written byte and the later restored PC reflect only the sequence in progress. It produces the second by loading the pointer with 7Eh through the direct write port before a call, so the high byte lands at 00h. It also loads 5Fh and pushes 33 bytes to reach the overflow from a realistic stack base.

// File: rtl/stk_pkg.sv
// Package: shared types for the stack pointer and call/return unit.
// Assumes: a single clock domain; no parameters are needed here.
package stk_pkg;

    // State of the two-cycle call/return sequencer
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_CALL2 = 2'd1,
        SEQ_RET2  = 2'd2
    } seq_state_t;

    // Operation picked by the request arbiter in an idle cycle
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_SPWR = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_PUSH = 3'd4,
        OP_POP  = 3'd5
    } op_t;

endpackage

// File: rtl/stk_arb.sv
// Module: stk_arb
// Picks at most one request per idle cycle. The fixed priority is
// direct write, call, return, push, pop.
// Assumes: 'idle' is low during the second cycle of a call or return;
// no request is taken then.
module stk_arb
    import stk_pkg::*;
(
    input  logic idle,
    input  logic sp_wr_en,
    input  logic call_req,
    input  logic ret_req,
    input  logic push_req,
    input  logic pop_req,
    output op_t  op
);

    // Priority select of the single accepted operation
    always_comb begin
        op = OP_NONE;
        if (idle) begin
            if (sp_wr_en)      op = OP_SPWR;
            else if (call_req) op = OP_CALL;
            else if (ret_req)  op = OP_RET;
            else if (push_req) op = OP_PUSH;
            else if (pop_req)  op = OP_POP;
        end
    end

endmodule

// File: rtl/stk_ptr.sv
// Module: stk_ptr
// Holds the stack pointer. Steps it up or down modulo 2**ADDR_W (clearing
// the upper bits), loads it directly, and pulses 'ovf' after an upward
// wrap.
// Assumes: SP_W > ADDR_W; inc and dec are never high together; load wins.
module stk_ptr #(
    parameter int              SP_W      = 8,
    parameter int              ADDR_W    = 7,
    parameter logic [SP_W-1:0] RESET_VAL = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SP_W-1:0] load_val,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up,
    output logic [SP_W-1:0] sp_dn,
    output logic            ovf
);

    localparam int                PAD = SP_W - ADDR_W;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [SP_W-1:0]   sp_q;
    logic              ovf_q;
    logic [ADDR_W-1:0] low;

    assign low   = sp_q[ADDR_W-1:0];
    assign sp_up = {{PAD{1'b0}}, low + ONE};
    assign sp_dn = {{PAD{1'b0}}, low - ONE};
    assign sp    = sp_q;
    assign ovf   = ovf_q;

    // Pointer register and one-cycle wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= RESET_VAL;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load) begin
                sp_q <= load_val;
            end else if (inc) begin
                sp_q  <= sp_up;
                ovf_q <= &low;
            end else if (dec) begin
                sp_q <= sp_dn;
            end
        end
    end

    // R8: the wrap flag only follows a step that landed on address zero
    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (sp[ADDR_W-1:0] == '0));

    // R7: the arbiter never asks for both directions at once
    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));

endmodule

// File: rtl/stk_mem.sv
// Module: stk_mem
// Stack storage with one synchronous write port and an asynchronous read port.
// Assumes: the contents are not reset; a location is read only after it has
// been written.
module stk_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Write one byte per cycle
    always_ff @(posedge clk) begin
        if (we) words[addr] <= wdata;
    end

    // Read the addressed byte without a clock
    assign rdata = words[addr];

    // R2: a write never goes to an undefined location
    assert_write_addr_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(addr));

endmodule

// File: rtl/stk_seq.sv
// Module: stk_seq
// Sequencer for the two-cycle call and return. On a call it keeps the high
// return byte for the second write. On a return it keeps the top entry read
// in the first cycle, joins it with the second read, and pulses pc_valid.
// Assumes: call_go and ret_go are only given while busy is low.
module stk_seq
    import stk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                call_go,
    input  logic                ret_go,
    input  logic [DATA_W-1:0]   hi_in,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                busy,
    output logic                wr2,
    output logic                rd2,
    output logic [DATA_W-1:0]   hi_byte,
    output logic [2*DATA_W-1:0] pc_out,
    output logic                pc_valid
);

    seq_state_t          state;
    logic [DATA_W-1:0]   hold_q;
    logic [2*DATA_W-1:0] pc_q;
    logic                pcv_q;

    assign wr2      = (state == SEQ_CALL2);
    assign rd2      = (state == SEQ_RET2);
    assign busy     = wr2 | rd2;
    assign hi_byte  = hold_q;
    assign pc_out   = pc_q;
    assign pc_valid = pcv_q;

    // State advance: each sequence owns exactly one extra cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (call_go)     state <= SEQ_CALL2;
                    else if (ret_go) state <= SEQ_RET2;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Holding byte: high return byte on a call, top entry on a return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (call_go) begin
            hold_q <= hi_in;
        end else if (ret_go) begin
            hold_q <= rd_data;
        end
    end

    // Restored PC and its one-cycle valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            pcv_q <= 1'b0;
        end else begin
            pcv_q <= rd2;
            if (rd2) pc_q <= {hold_q, rd_data};
        end
    end

    // R6: the extra cycle lasts exactly one clock
    assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6: no new sequence starts while one is in progress
    assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_go || ret_go) |-> !busy);

    // R5: the second read of a return is followed by a valid PC
    assert_ret_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd2 |=> pc_valid);

endmodule

// File: rtl/stack_call_unit.sv
// Module: stack_call_unit (top)
// Stack pointer and subroutine call/return unit for an upward-growing stack
// in internal RAM. A push pre-increments and a pop post-decrements. A call
// saves the PC low byte first; a return restores the high byte from the top.
// Assumes: one request is taken per idle cycle; the RAM is not reset.
module stack_call_unit
    import stk_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 7,
    parameter logic [DATA_W-1:0] SP_RESET = 8'h07
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_req,
    input  logic [DATA_W-1:0]   push_data,
    input  logic                pop_req,
    input  logic                call_req,
    input  logic [2*DATA_W-1:0] call_addr,
    input  logic                ret_req,
    input  logic                sp_wr_en,
    input  logic [DATA_W-1:0]   sp_wr_data,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                ram_we,
    output logic                ram_re,
    output logic [DATA_W-1:0]   pop_data,
    output logic                pop_valid,
    output logic [2*DATA_W-1:0] pc_out,
    output logic                pc_valid,
    output logic                busy,
    output logic [DATA_W-1:0]   sp_out,
    output logic                ovf
);

    localparam int PC_W = 2 * DATA_W;

    op_t               op;
    logic              seq_busy, seq_wr2, seq_rd2;
    logic [DATA_W-1:0] seq_hi;
    logic [DATA_W-1:0] sp, sp_up, sp_dn;
    logic              step_up, step_dn, load;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] pop_q;
    logic              popv_q;

    // Request arbitration
    stk_arb u_arb (
        .idle     (!seq_busy),
        .sp_wr_en (sp_wr_en),
        .call_req (call_req),
        .ret_req  (ret_req),
        .push_req (push_req),
        .pop_req  (pop_req),
        .op       (op)
    );

    // Pointer control derived from the chosen operation or sequence step
    always_comb begin
        load    = (op == OP_SPWR);
        step_up = (op == OP_CALL) || (op == OP_PUSH) || seq_wr2;
        step_dn = (op == OP_RET)  || (op == OP_POP)  || seq_rd2;
    end

    stk_ptr #(
        .SP_W      (DATA_W),
        .ADDR_W    (ADDR_W),
        .RESET_VAL (SP_RESET)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (sp_wr_data),
        .inc      (step_up),
        .dec      (step_dn),
        .sp       (sp),
        .sp_up    (sp_up),
        .sp_dn    (sp_dn),
        .ovf      (ovf)
    );

    stk_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_go  (op == OP_CALL),
        .ret_go   (op == OP_RET),
        .hi_in    (call_addr[PC_W-1:DATA_W]),
        .rd_data  (rdata),
        .busy     (seq_busy),
        .wr2      (seq_wr2),
        .rd2      (seq_rd2),
        .hi_byte  (seq_hi),
        .pc_out   (pc_out),
        .pc_valid (pc_valid)
    );

    // RAM address, data and strobes: writes go above SP, reads at SP
    always_comb begin
        ram_we   = step_up;
        ram_re   = step_dn;
        ram_addr = step_up ? sp_up[ADDR_W-1:0] : sp[ADDR_W-1:0];
        if (op == OP_PUSH)      ram_wdata = push_data;
        else if (op == OP_CALL) ram_wdata = call_addr[DATA_W-1:0];
        else                    ram_wdata = seq_hi;
    end

    stk_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (rdata)
    );

    // Popped byte register and its one-cycle valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_q  <= '0;
            popv_q <= 1'b0;
        end else begin
            popv_q <= (op == OP_POP);
            if (op == OP_POP) pop_q <= rdata;
        end
    end

    assign pop_data  = pop_q;
    assign pop_valid = popv_q;
    assign busy      = seq_busy;
    assign sp_out    = sp;

    // R2: every write lands where the pointer points afterwards
    assert_push_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (sp_out[ADDR_W-1:0] == $past(ram_addr)));

    // R3: a popped byte always follows a read access
    assert_pop_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(ram_re));

    // R9: an accepted direct write makes no RAM access
    assert_direct_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en && !busy) |-> (!ram_we && !ram_re));

endmodule

// File: tb/stack_call_unit_test.sv
// Scoreboard bench: the driver tasks keep a reference model of the pointer
// and RAM and queue the expected popped bytes and PCs; a monitor compares
// them when the valid flags appear.
module stack_call_unit_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_req, pop_req, call_req, ret_req, sp_wr_en;
    logic [7:0]  push_data, sp_wr_data;
    logic [15:0] call_addr;
    logic [6:0]  ram_addr;
    logic [7:0]  ram_wdata, pop_data, sp_out;
    logic        ram_we, ram_re, pop_valid, pc_valid, busy, ovf;
    logic [15:0] pc_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_sp;
    logic [7:0]  m_mem [128];
    logic [7:0]  exp_pop_q [$];
    logic [15:0] exp_pc_q [$];
    logic [7:0]  e8;
    logic [15:0] e16;

    always #2 clk = ~clk;

    stack_call_unit uut (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .call_req(call_req), .call_addr(call_addr), .ret_req(ret_req),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
        .pop_data(pop_data), .pop_valid(pop_valid), .pc_out(pc_out), .pc_valid(pc_valid),
        .busy(busy), .sp_out(sp_out), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] up(input logic [7:0] s);
        return {1'b0, s[6:0] + 7'd1};
    endfunction

    function automatic logic [7:0] down(input logic [7:0] s);
        return {1'b0, s[6:0] - 7'd1};
    endfunction

    task automatic clear_in();
        push_req = 0; pop_req = 0; call_req = 0; ret_req = 0; sp_wr_en = 0;
        push_data = 0; sp_wr_data = 0; call_addr = 0;
    endtask

    // One accepted request (plus the busy cycle of a call or return)
    task automatic strobe(input bit spw, input logic [7:0] spd, input bit cl,
                          input logic [15:0] ca, input bit rt, input bit ps,
                          input logic [7:0] pd, input bit pp, input bit noise,
                          input string req);
        logic [7:0] a;
        logic [7:0] hi;
        logic [7:0] lo;
        bit wrap;
        wrap = 0; hi = 0;
        sp_wr_en = spw; sp_wr_data = spd; call_req = cl; call_addr = ca;
        ret_req = rt; push_req = ps; push_data = pd; pop_req = pp;
        #0.5;
        if (spw) begin
            check(!ram_we && !ram_re, req, "RAM access on direct write", ram_we, 0);
            m_sp = spd;
        end else if (cl || ps) begin
            a = up(m_sp);
            wrap = (m_sp[6:0] == 7'h7f);
            check(ram_we == 1, req, "write strobe", ram_we, 1);
            check(ram_addr == a[6:0], req, "write address", ram_addr, a[6:0]);
            check(ram_wdata == (cl ? ca[7:0] : pd), req, "write data", ram_wdata,
                  cl ? ca[7:0] : pd);
            m_mem[a[6:0]] = cl ? ca[7:0] : pd;
            m_sp = a;
        end else if (rt || pp) begin
            check(ram_re && !ram_we, req, "read strobe", ram_re, 1);
            check(ram_addr == m_sp[6:0], req, "read address", ram_addr, m_sp[6:0]);
            if (rt) hi = m_mem[m_sp[6:0]];
            else exp_pop_q.push_back(m_mem[m_sp[6:0]]);
            m_sp = down(m_sp);
        end
        @(posedge clk); #0.5;
        clear_in();
        check(ovf == wrap, req, "overflow flag", ovf, wrap);
        if (!spw && (cl || rt)) begin
            check(busy == 1, req, "busy in second cycle", busy, 1);
            if (noise) begin
                push_req = 1; push_data = 8'hEE; pop_req = 1; call_req = 1;
                call_addr = 16'hFFFF; ret_req = 1; sp_wr_en = 1; sp_wr_data = 8'h33;
            end
            #0.5;
            wrap = 0;
            if (cl) begin
                a = up(m_sp);
                wrap = (m_sp[6:0] == 7'h7f);
                check(ram_we == 1 && ram_addr == a[6:0], req, "second write address",
                      ram_addr, a[6:0]);
                check(ram_wdata == ca[15:8], req, "second write data", ram_wdata, ca[15:8]);
                m_mem[a[6:0]] = ca[15:8];
                m_sp = a;
            end else begin
                check(ram_we == 0 && ram_addr == m_sp[6:0], req, "second read address",
                      ram_addr, m_sp[6:0]);
                lo = m_mem[m_sp[6:0]];
                exp_pc_q.push_back({hi, lo});
                m_sp = down(m_sp);
            end
            @(posedge clk); #0.5;
            clear_in();
            check(ovf == wrap, req, "overflow flag after second access", ovf, wrap);
            check(busy == 0, req, "busy released", busy, 0);
        end
        check(sp_out == m_sp, req, "stack pointer", sp_out, m_sp);
    endtask

    task automatic push(input logic [7:0] b, input string req);
        strobe(0, 0, 0, 0, 0, 1, b, 0, 0, req);
    endtask
    task automatic pop(input string req);
        strobe(0, 0, 0, 0, 0, 0, 0, 1, 0, req);
    endtask
    task automatic call(input logic [15:0] a, input bit noise, input string req);
        strobe(0, 0, 1, a, 0, 0, 0, 0, noise, req);
    endtask
    task automatic ret(input bit noise, input string req);
        strobe(0, 0, 0, 0, 1, 0, 0, 0, noise, req);
    endtask
    task automatic wsp(input logic [7:0] v, input string req);
        strobe(1, v, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    // Monitor: compares produced results against the queued expectations
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            if (pop_valid) begin
                if (exp_pop_q.size() == 0) check(0, "R3", "unexpected pop_valid", 1, 0);
                else begin
                    e8 = exp_pop_q.pop_front();
                    check(pop_data == e8, "R3", "popped byte", pop_data, e8);
                end
            end
            if (pc_valid) begin
                if (exp_pc_q.size() == 0) check(0, "R5", "unexpected pc_valid", 1, 0);
                else begin
                    e16 = exp_pc_q.pop_front();
                    check(pc_out == e16, "R5", "restored PC", pc_out, e16);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1;
        m_sp = 8'h07;
        #0.5;
        // R1: reset state
        check(sp_out == 8'h07, "R1", "reset pointer", sp_out, 8'h07);
        check(!busy && !pop_valid && !pc_valid && !ovf && !ram_we, "R1",
              "reset flags", {busy, pop_valid, pc_valid, ovf, ram_we}, 0);
        @(posedge clk); #0.5;

        // R1/R2: first pushes land at 08h and 09h
        push(8'h55, "R1");
        push(8'h4A, "R2");
        check(m_mem[8] == 8'h55 && sp_out == 8'h09, "R2", "push example", sp_out, 8'h09);
        pop("R3");
        pop("R3");

        // R4/R5: call and return with two addresses
        call(16'h0207, 0, "R4");
        ret(0, "R5");
        call(16'h8AF2, 0, "R4");
        push(8'h11, "R2");
        pop("R3");
        ret(0, "R5");

        // R6: every strobe raised during the busy cycle is ignored
        call(16'h1234, 1, "R6");
        ret(1, "R6");

        // R7: priority among simultaneous requests
        strobe(0, 0, 0, 0, 0, 1, 8'h77, 1, 0, "R7");               // push over pop
        strobe(0, 0, 1, 16'hBEEF, 0, 1, 8'h99, 0, 0, "R7");        // call over push
        strobe(0, 0, 0, 0, 1, 0, 0, 1, 0, "R7");                   // return over pop
        pop("R7");
        strobe(1, 8'h20, 1, 16'hCAFE, 1, 1, 8'h66, 1, 0, "R9");    // write over all
        push(8'h3C, "R9");
        check(m_mem[8'h21] == 8'h3C, "R9", "push after direct write", ram_addr, 8'h21);

        // R10: stack based at 5Fh holds 32 bytes, then wraps
        wsp(8'h5F, "R10");
        for (int i = 0; i < 32; i++) push(8'(8'h80 + i), "R10");
        check(sp_out == 8'h7F, "R10", "pointer after 32 pushes", sp_out, 8'h7F);
        push(8'hA5, "R8");
        check(sp_out == 8'h00, "R8", "pointer after wrap", sp_out, 8'h00);
        pop("R8");
        pop("R8");
        pop("R8");

        // R8: pointer with bit 7 set, and a call straddling the wrap
        wsp(8'h90, "R8");
        push(8'h5A, "R8");
        check(sp_out == 8'h11, "R8", "top bit cleared by step", sp_out, 8'h11);
        pop("R8");
        wsp(8'h7E, "R8");
        call(16'hABCD, 0, "R8");
        ret(0, "R8");

        @(posedge clk); @(posedge clk); #0.5;
        check(exp_pop_q.size() == 0, "R3", "popped bytes outstanding", exp_pop_q.size(), 0);
        check(exp_pc_q.size() == 0, "R5", "restored PCs outstanding", exp_pc_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule